// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block keeps the fetch address of a small Harvard-style processor core. Every cycle it picks one operation from its request strobes: restart at the reset vector, enter the interrupt vector, jump or call to a supplied target, return to a saved address, step to the next word, or hold. The logical counter is 13 bits wide, which covers an 8K-word space. Only 2K words are built, so the physical fetch address is the low 11 bits of the counter, and higher addresses alias onto the built region.

Return addresses sit in an eight-entry circular stack of full-width entries. A call or an interrupt entry pushes an entry, and a return pops one. Return-with-literal uses the same pop as a plain return. Overflow silently replaces the oldest entry. Underflow reads whichever slot the pointer wraps onto. No flag reports either case. An accepted return-from-interrupt also raises a one-cycle strobe, which outside logic uses to turn the global interrupt enable back on.

The operation is chosen combinationally, in fixed priority, as one value of an enumerated type:
- `OP_RESET` is the restart.
- `OP_VECTOR` is interrupt entry.
- `OP_LINK` is a call.
- `OP_BRANCH` is a load.
- `OP_UNWIND` is a return.
- `OP_ADVANCE` is an increment.
- `OP_HOLD` applies when no request is present.

The counter register moves on every clock edge to the address that the selected operation produces. `OP_HOLD` returns it to itself.

Top module: `pc_seq_unit`

## Requirements
- R1: With `rst` high at a clock edge, the next `pc_out` is 0x0000, `gie_reen` is 0 and the stack becomes empty.
- R2: With only `step_en` high, `pc_out` becomes the old value plus one modulo 8192, so 0x1FFF is followed by 0x0000.
- R3: `fetch_addr` always equals bits 10:0 of `pc_out`, so addresses of 0x0800 and above alias into the 2K region.
- R4: `load_en` without `call_en` moves `pc_out` to `load_addr` and leaves the stack untouched.
- R5: `call_en` moves `pc_out` to `load_addr` and pushes the old `pc_out` plus one modulo 8192.
- R6: `irq_en` moves `pc_out` to 0x0004 and pushes the old `pc_out` unchanged.
- R7: `ret_en` or `reti_en` pops the stack. `pc_out` becomes the most recently pushed address that has not yet been popped.
- R8: The stack has 8 slots and wraps. After nine pushes, the pops return pushes nine down to two. A ninth pop returns push nine again, and a tenth returns push eight.
- R9: Requests in the same cycle are served in this order: reset, interrupt entry, call, load, return, increment. Only the winner changes the counter or the stack.
- R10: `gie_reen` is high for exactly the one cycle after a `reti_en` that wins arbitration. It stays low after a plain return and after a `reti_en` that loses arbitration.
- R11: With no request, `pc_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance to the next word |
| load_en | input | 1 | Jump to `load_addr` without saving a return address |
| load_addr | input | 13 | Jump or call target |
| call_en | input | 1 | Call `load_addr` and push the return address |
| ret_en | input | 1 | Plain return, or return with literal |
| reti_en | input | 1 | Return from interrupt |
| irq_en | input | 1 | Interrupt entry |
| pc_out | output | 13 | Logical program counter |
| fetch_addr | output | 11 | Physical fetch address (aliased counter) |
| gie_reen | output | 1 | One-cycle strobe to re-enable interrupts |

## Verification
The properties assume that `rst` is high from time zero and that every request input has a known level at every rising edge after reset. The bench meets this by starting in reset and driving all strobes and the target on falling edges only. It also clears every strobe that a step does not name.

Popped values depend on stack slots that reset does not clear. The stimulus therefore pops a slot only after it has been written since time zero, including in the deliberate underflow after the wrap test.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    // Operation chosen for the current cycle, listed in no priority order.
    typedef enum logic [2:0] {
        OP_HOLD    = 3'd0,
        OP_RESET   = 3'd1,
        OP_VECTOR  = 3'd2,
        OP_LINK    = 3'd3,
        OP_BRANCH  = 3'd4,
        OP_UNWIND  = 3'd5,
        OP_ADVANCE = 3'd6
    } pc_op_e;

endpackage

// File: rtl/pc_op_arbiter.sv
module pc_op_arbiter
    import pc_seq_pkg::*;
(
    input  logic   rst_i,
    input  logic   irq_i,
    input  logic   call_i,
    input  logic   load_i,
    input  logic   ret_i,
    input  logic   reti_i,
    input  logic   step_i,
    output pc_op_e op_o,
    output logic   push_o,
    output logic   pop_o,
    output logic   reti_won_o
);

    // Fixed priority: restart, interrupt, call, load, return, step.
    always_comb begin
        op_o       = OP_HOLD;
        reti_won_o = 1'b0;
        if (rst_i) begin
            op_o = OP_RESET;
        end else if (irq_i) begin
            op_o = OP_VECTOR;
        end else if (call_i) begin
            op_o = OP_LINK;
        end else if (load_i) begin
            op_o = OP_BRANCH;
        end else if (ret_i || reti_i) begin
            op_o       = OP_UNWIND;
            reti_won_o = reti_i;
        end else if (step_i) begin
            op_o = OP_ADVANCE;
        end
    end

    assign push_o = (op_o == OP_VECTOR) || (op_o == OP_LINK);
    assign pop_o  = (op_o == OP_UNWIND);

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_up;
    logic [PW-1:0] sp_down;

    // Explicit wrap keeps the ring correct for depths that are not powers of two.
    assign sp_up   = (sp_q == LAST) ? '0 : sp_q + PW'(1);
    assign sp_down = (sp_q == '0) ? LAST : sp_q - PW'(1);

    // The most recent entry sits just below the write pointer.
    assign top_o = slot_q[sp_down];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push_i) begin
            sp_q <= sp_up;
        end else if (pop_i) begin
            sp_q <= sp_down;
        end
    end

    // Storage is not reset; the pointer alone defines the stack contents.
    always_ff @(posedge clk) begin
        if (!rst && push_i) begin
            slot_q[sp_q] <= push_data_i;
        end
    end

endmodule

// File: rtl/pc_next_addr.sv
module pc_next_addr
    import pc_seq_pkg::*;
#(
    parameter int              PC_W      = 13,
    parameter logic [PC_W-1:0] RESET_VEC = '0,
    parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
    input  pc_op_e          op_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    input  logic [PC_W-1:0] popped_i,
    output logic [PC_W-1:0] next_o,
    output logic [PC_W-1:0] link_o
);

    logic [PC_W-1:0] pc_plus;

    // The adder is shared by stepping and by the call return address.
    assign pc_plus = pc_i + PC_W'(1);

    always_comb begin
        unique case (op_i)
            OP_RESET:   next_o = RESET_VEC;
            OP_VECTOR:  next_o = IRQ_VEC;
            OP_LINK:    next_o = target_i;
            OP_BRANCH:  next_o = target_i;
            OP_UNWIND:  next_o = popped_i;
            OP_ADVANCE: next_o = pc_plus;
            OP_HOLD:    next_o = pc_i;
            default:    next_o = pc_i;
        endcase
    end

    // An interrupt resumes at the word it preempted; a call resumes after itself.
    assign link_o = (op_i == OP_VECTOR) ? pc_i : pc_plus;

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pc_seq_pkg::*;
#(
    parameter int              PC_W        = 13,
    parameter int              PHYS_W      = 11,
    parameter int              STACK_DEPTH = 8,
    parameter logic [PC_W-1:0] RESET_VEC   = '0,
    parameter logic [PC_W-1:0] IRQ_VEC     = PC_W'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [PC_W-1:0]   load_addr,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic              reti_en,
    input  logic              irq_en,
    output logic [PC_W-1:0]   pc_out,
    output logic [PHYS_W-1:0] fetch_addr,
    output logic              gie_reen
);

    pc_op_e          op;
    logic            push;
    logic            pop;
    logic            reti_won;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] link_addr;
    logic [PC_W-1:0] stack_top;
    logic            gie_q;

    pc_op_arbiter u_arb (
        .rst_i      (rst),
        .irq_i      (irq_en),
        .call_i     (call_en),
        .load_i     (load_en),
        .ret_i      (ret_en),
        .reti_i     (reti_en),
        .step_i     (step_en),
        .op_o       (op),
        .push_o     (push),
        .pop_o      (pop),
        .reti_won_o (reti_won)
    );

    pc_next_addr #(
        .PC_W      (PC_W),
        .RESET_VEC (RESET_VEC),
        .IRQ_VEC   (IRQ_VEC)
    ) u_next (
        .op_i     (op),
        .pc_i     (pc_q),
        .target_i (load_addr),
        .popped_i (stack_top),
        .next_o   (pc_d),
        .link_o   (link_addr)
    );

    pc_ret_stack #(
        .W     (PC_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (link_addr),
        .top_o       (stack_top)
    );

    // State register; the reset path also runs through the arbiter as OP_RESET.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_VEC;
            gie_q <= 1'b0;
        end else begin
            pc_q  <= pc_d;
            gie_q <= reti_won;
        end
    end

    // Output process.
    always_comb begin
        pc_out     = pc_q;
        fetch_addr = pc_q[PHYS_W-1:0];
        gie_reen   = gie_q;
    end

endmodule

// File: rtl/pc_seq_unit_chk.sv
module pc_seq_unit_chk #(
    parameter int              PC_W    = 13,
    parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
    input logic            clk,
    input logic            rst,
    input logic            step_en,
    input logic            load_en,
    input logic [PC_W-1:0] load_addr,
    input logic            call_en,
    input logic            ret_en,
    input logic            reti_en,
    input logic            irq_en,
    input logic [PC_W-1:0] pc_out,
    input logic            gie_reen
);

    logic any_req;
    assign any_req = step_en | load_en | call_en | ret_en | reti_en | irq_en;

    assert_reset_vec_R1: assert property (@(posedge clk)
        rst |=> (pc_out == '0) && !gie_reen);

    assert_step_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en && !call_en && !ret_en && !reti_en && !irq_en)
        |=> pc_out == PC_W'($past(pc_out) + PC_W'(1)));

    assert_load_target_R4: assert property (@(posedge clk) disable iff (rst)
        (load_en && !call_en && !irq_en) |=> pc_out == $past(load_addr));

    assert_call_target_R5: assert property (@(posedge clk) disable iff (rst)
        (call_en && !irq_en) |=> pc_out == $past(load_addr));

    assert_irq_vector_R6: assert property (@(posedge clk) disable iff (rst)
        irq_en |=> pc_out == IRQ_VEC);

    assert_call_beats_return_R9: assert property (@(posedge clk) disable iff (rst)
        (call_en && !irq_en && (ret_en || reti_en || step_en))
        |=> pc_out == $past(load_addr));

    assert_gie_source_R10: assert property (@(posedge clk) disable iff (rst)
        gie_reen |-> $past(reti_en && !irq_en && !call_en && !load_en));

    assert_gie_single_R10: assert property (@(posedge clk) disable iff (rst)
        gie_reen |=> !gie_reen || $past(reti_en));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> $stable(pc_out));

endmodule

bind pc_seq_unit pc_seq_unit_chk #(
    .PC_W    (PC_W),
    .IRQ_VEC (IRQ_VEC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .load_en   (load_en),
    .load_addr (load_addr),
    .call_en   (call_en),
    .ret_en    (ret_en),
    .reti_en   (reti_en),
    .irq_en    (irq_en),
    .pc_out    (pc_out),
    .gie_reen  (gie_reen)
);

// File: tb/pc_seq_unit_bench.sv
module pc_seq_unit_bench;

    localparam int PC_W   = 13;
    localparam int PHYS_W = 11;
    localparam int DEPTH  = 8;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic            gie;
        string           tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_en = 1'b0, load_en = 1'b0, call_en = 1'b0;
    logic              ret_en = 1'b0, reti_en = 1'b0, irq_en = 1'b0;
    logic [PC_W-1:0]   load_addr = '0;
    logic [PC_W-1:0]   pc_out;
    logic [PHYS_W-1:0] fetch_addr;
    logic              gie_reen;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    exp_t exp_q[$];

    // Reference state, built from the requirements.
    logic [PC_W-1:0] m_pc = '0;
    logic [PC_W-1:0] m_stk [DEPTH];
    int              m_sp = 0;

    always #10 clk = ~clk;

    pc_seq_unit u_pc_seq_unit (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .load_en    (load_en),
        .load_addr  (load_addr),
        .call_en    (call_en),
        .ret_en     (ret_en),
        .reti_en    (reti_en),
        .irq_en     (irq_en),
        .pc_out     (pc_out),
        .fetch_addr (fetch_addr),
        .gie_reen   (gie_reen)
    );

    task automatic m_push(input logic [PC_W-1:0] v);
        m_stk[m_sp] = v;
        m_sp = (m_sp + 1) % DEPTH;
    endtask

    task automatic m_pop(output logic [PC_W-1:0] v);
        m_sp = (m_sp + DEPTH - 1) % DEPTH;
        v = m_stk[m_sp];
    endtask

    // Driver: apply one cycle of requests and queue the expected result.
    task automatic drive(input bit r, input bit irq, input bit call, input bit ld,
                         input logic [PC_W-1:0] tgt, input bit rt, input bit rti,
                         input bit st, input string tag);
        exp_t e;
        logic [PC_W-1:0] v;
        @(negedge clk);
        rst = r; irq_en = irq; call_en = call; load_en = ld; load_addr = tgt;
        ret_en = rt; reti_en = rti; step_en = st;
        e.gie = 1'b0;
        if (r) begin
            m_pc = '0; m_sp = 0;
        end else if (irq) begin
            m_push(m_pc); m_pc = 13'h0004;
        end else if (call) begin
            m_push(PC_W'(m_pc + 1)); m_pc = tgt;
        end else if (ld) begin
            m_pc = tgt;
        end else if (rt || rti) begin
            m_pop(v); m_pc = v; e.gie = rti;
        end else if (st) begin
            m_pc = PC_W'(m_pc + 1);
        end
        e.pc = m_pc; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (pc_out !== e.pc || fetch_addr !== e.pc[PHYS_W-1:0] || gie_reen !== e.gie) begin
                    n_fail++;
                    $display("FAIL %s: pc=%h fetch=%h gie=%b expected pc=%h fetch=%h gie=%b",
                             e.tag, pc_out, fetch_addr, gie_reen,
                             e.pc, e.pc[PHYS_W-1:0], e.gie);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
        drive(1, 0, 0, 0, '0, 0, 0, 0, "R1");
        drive(1, 0, 0, 0, '0, 0, 0, 0, "R1");
        drive(0, 0, 0, 0, '0, 0, 0, 1, "R2");
        drive(0, 0, 0, 0, '0, 0, 0, 1, "R2");
        drive(0, 0, 0, 0, '0, 0, 0, 1, "R2");
        drive(0, 0, 0, 0, '0, 0, 0, 0, "R11");
        drive(0, 0, 0, 0, '0, 0, 0, 0, "R11");
        drive(0, 0, 0, 1, 13'h1ABC, 0, 0, 0, "R3");
        drive(0, 0, 0, 0, '0, 0, 0, 1, "R3");
        drive(0, 0, 0, 1, 13'h1FFF, 0, 0, 0, "R4");
        drive(0, 0, 0, 0, '0, 0, 0, 1, "R2");
        drive(0, 0, 1, 0, 13'h0200, 0, 0, 0, "R5");
        drive(0, 1, 0, 0, '0, 0, 0, 0, "R6");
        drive(0, 0, 0, 0, '0, 0, 1, 0, "R10");
        drive(0, 0, 0, 0, '0, 0, 0, 0, "R10");
        drive(0, 0, 0, 0, '0, 1, 0, 0, "R7");
        drive(0, 0, 0, 1, 13'h1FFF, 0, 0, 0, "R4");
        drive(0, 0, 1, 0, 13'h0040, 0, 0, 0, "R5");
        drive(0, 0, 0, 0, '0, 1, 0, 0, "R7");
        // Simultaneous requests.
        drive(1, 1, 1, 0, 13'h0555, 0, 0, 1, "R9");
        drive(0, 1, 1, 1, 13'h0666, 1, 0, 1, "R9");
        drive(0, 0, 1, 0, 13'h0300, 1, 0, 1, "R9");
        drive(0, 0, 0, 0, '0, 1, 0, 1, "R9");
        drive(0, 0, 0, 1, 13'h0077, 0, 1, 0, "R9");
        drive(0, 0, 0, 0, '0, 0, 1, 1, "R9");
        // Stack wrap and underflow.
        drive(1, 0, 0, 0, '0, 0, 0, 0, "R1");
        for (int i = 0; i < 9; i++)
            drive(0, 0, 1, 0, PC_W'(13'h0100 + i * 16), 0, 0, 0, "R8");
        for (int i = 0; i < 10; i++)
            drive(0, 0, 0, 0, '0, 1, 0, 0, "R8");
        drive(0, 0, 0, 0, '0, 0, 0, 0, "R11");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d results outstanding, expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule